// File: doc/BRIEF.md
# Two-Byte Global Command Decoder

This block sits behind a host control port and turns a stream of bytes into global control actions for an eight-channel voice codec. Bytes arrive one at a time with a valid strobe. They are taken in pairs. The first byte of a pair is an opcode and the second is its operand. Bit 7 of the opcode gives the direction: 1 writes and 0 reads. A readable register is selected by the remaining seven bits, so one register answers a read opcode and a write opcode that differ only in bit 7.

The block holds two global registers. The first is a 4-bit master-clock rate code. The second is a mask with one enable bit per channel, and a channel accepts local and coefficient commands only while its bit is set. Three opcodes have no read form: the idle opcode, the local-clear opcode and the full-restart opcode. Each of them acts only when its operand byte is 0xFF. Any other operand cancels the command and sets a sticky error flag. The local-clear opcode sends a one-cycle pulse to the per-channel register banks and leaves the global registers alone. The full-restart opcode sends a one-cycle pulse to the whole device and puts the global registers back to their reset values.

A read answers one cycle after its opcode byte, with a byte and a valid strobe. The operand slot that follows a read opcode is still consumed and is otherwise ignored.

Top module: `glob_cmd_dec`

## Requirements
- R1: After a synchronous reset, `clk_sel` is 4'b0010, `chan_en` is all zeros, `seq_err`, `rd_valid`, `local_rst` and `dev_rst` are 0, and the next accepted byte is treated as an opcode.
- R2: Only cycles with `byte_valid` high carry a byte, and any number of idle cycles may separate bytes. Accepted bytes alternate strictly between opcode and operand.
- R3: Opcode 0x20 (version read) makes `rd_valid` high for exactly the cycle after the opcode byte, with `rd_data` equal to 0x01.
- R4: The pair 0xA4 plus operand writes operand bits 3:0 into `clk_sel` when the code is legal, and operand bits 7:4 have no effect. Opcode 0x24 reads back {4'b0000, clk_sel}. The legal codes are 0000, 0001, 0010, 0100, 0101, 0110, 1100, 1101 and 1110.
- R5: A 0xA4 write whose bits 3:0 are not a legal code leaves `clk_sel` unchanged.
- R6: The pair 0xA5 plus operand writes the operand into `chan_en`, so bit i enables channel i+1. Opcode 0x25 reads the mask back.
- R7: The pair 0xA2 plus 0xFF makes `local_rst` high for one cycle and leaves `clk_sel`, `chan_en` and `seq_err` unchanged.
- R8: The pair 0xA3 plus 0xFF makes `dev_rst` high for one cycle. In that same cycle `clk_sel` is back to 4'b0010, `chan_en` is 0 and `seq_err` is 0.
- R9: Opcode 0xA0, 0xA2 or 0xA3 followed by an operand other than 0xFF produces no pulse and no register change, and sets `seq_err`. The flag then stays set until reset or a full restart.
- R10: The pair 0xA0 plus 0xFF (idle) changes no output.
- R11: Any other opcode consumes its operand and has no side effect. If it is a read (bit 7 = 0), `rd_data` is 0x00 with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A byte is present on `byte_in` this cycle |
| byte_in | input | 8 | Incoming opcode or operand byte |
| rd_valid | output | 1 | Read reply is valid |
| rd_data | output | 8 | Read reply byte |
| clk_sel | output | 4 | Master-clock rate code |
| chan_en | output | 8 | Per-channel command-acceptance enable |
| local_rst | output | 1 | One-cycle pulse that clears per-channel registers |
| dev_rst | output | 1 | One-cycle pulse that restarts the whole device |
| seq_err | output | 1 | Sticky flag for a bad operand after a write-only opcode |

## Verification
The assertions assume that the reset is held for at least one clock edge, so that the pairing phase starts from a known point. They also assume that `byte_in` is relevant only while `byte_valid` is high. The stimulus raises `byte_valid` for single cycles, with zero to two idle cycles between bytes, so every pair is framed the way the block expects. Random operands, including illegal clock codes and operands other than 0xFF after write-only opcodes, cover the reject paths without ever breaking the framing.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int BYTE_W = 8;
  localparam int CSEL_W = 4;

  localparam logic [BYTE_W-1:0] OP_IDLE   = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_VER    = 8'h20;
  localparam logic [BYTE_W-1:0] OP_LCLR   = 8'hA2;
  localparam logic [BYTE_W-1:0] OP_FULL   = 8'hA3;
  localparam logic [BYTE_W-1:0] OP_CSEL_W = 8'hA4;
  localparam logic [BYTE_W-1:0] OP_MASK_W = 8'hA5;
  localparam logic [BYTE_W-2:0] RA_VER    = 7'h20;
  localparam logic [BYTE_W-2:0] RA_CSEL   = 7'h24;
  localparam logic [BYTE_W-2:0] RA_MASK   = 7'h25;
  localparam logic [BYTE_W-1:0] KEY_BYTE  = 8'hFF;

  localparam logic [CSEL_W-1:0] CSEL_DEF  = 4'b0010;

  function automatic logic csel_legal(input logic [CSEL_W-1:0] c);
    case (c)
      4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0101,
      4'b0110, 4'b1100, 4'b1101, 4'b1110: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_wonly(input logic [BYTE_W-1:0] op);
    return (op == OP_IDLE) || (op == OP_LCLR) || (op == OP_FULL);
  endfunction
endpackage

// File: rtl/gcd_framer.sv
module gcd_framer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  output logic          op_fire,
  output logic          arg_fire,
  output logic [DW-1:0] op_q
);
  logic in_arg;

  assign op_fire  = byte_valid && !in_arg;
  assign arg_fire = byte_valid && in_arg;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_arg <= 1'b0;
      op_q   <= '0;
    end else if (byte_valid) begin
      in_arg <= !in_arg;
      if (!in_arg) op_q <= byte_in;
    end
  end

  AST_ALT_PHASE: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> $stable(in_arg)); // R2
endmodule

// File: rtl/gcd_regs.sv
module gcd_regs
  import gcd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arg_fire,
  input  logic [DW-1:0]     op_q,
  input  logic [DW-1:0]     arg,
  output logic [CSEL_W-1:0] clk_sel,
  output logic [NCH-1:0]    chan_en,
  output logic              seq_err,
  output logic              local_rst,
  output logic              dev_rst
);
  logic key_ok, wonly, do_full, do_lclr, bad_arg, do_csel, do_mask;

  always_comb begin
    key_ok  = (arg == KEY_BYTE);
    wonly   = is_wonly(op_q);
    do_full = arg_fire && (op_q == OP_FULL) && key_ok;
    do_lclr = arg_fire && (op_q == OP_LCLR) && key_ok;
    bad_arg = arg_fire && wonly && !key_ok;
    do_csel = arg_fire && (op_q == OP_CSEL_W) && csel_legal(arg[CSEL_W-1:0]);
    do_mask = arg_fire && (op_q == OP_MASK_W);
  end

  always_ff @(posedge clk) begin
    if (rst || do_full) begin
      clk_sel <= CSEL_DEF;
      chan_en <= '0;
      seq_err <= 1'b0;
    end else begin
      if (do_csel) clk_sel <= arg[CSEL_W-1:0];
      if (do_mask) chan_en <= arg[NCH-1:0];
      if (bad_arg) seq_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      local_rst <= 1'b0;
      dev_rst   <= 1'b0;
    end else begin
      local_rst <= do_lclr;
      dev_rst   <= do_full;
    end
  end

  AST_CSEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    csel_legal(clk_sel)); // R5
  AST_LCLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    local_rst |=> !local_rst); // R7
  AST_FULL_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    dev_rst |-> (chan_en == '0 && clk_sel == CSEL_DEF && !seq_err)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_err) |-> dev_rst); // R9
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(arg_fire && (op_q == OP_MASK_W || op_q == OP_FULL)) |=> $stable(chan_en)); // R6
endmodule

// File: rtl/gcd_rdmux.sv
module gcd_rdmux
  import gcd_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NCH     = 8,
  parameter int VERSION = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_fire,
  input  logic [DW-1:0]     op_in,
  input  logic [CSEL_W-1:0] clk_sel,
  input  logic [NCH-1:0]    chan_en,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    case (op_in[DW-2:0])
      RA_VER:  sel_val = DW'(VERSION);
      RA_CSEL: sel_val[CSEL_W-1:0] = clk_sel;
      RA_MASK: sel_val[NCH-1:0] = chan_en;
      default: sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= op_fire && !op_in[DW-1];
      rd_data  <= (op_fire && !op_in[DW-1]) ? sel_val : '0;
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0); // R11
endmodule

// File: rtl/glob_cmd_dec.sv
module glob_cmd_dec
  import gcd_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int VERSION = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [3:0]  clk_sel,
  output logic [NCH-1:0] chan_en,
  output logic        local_rst,
  output logic        dev_rst,
  output logic        seq_err
);
  logic              op_fire, arg_fire;
  logic [BYTE_W-1:0] op_q;

  gcd_framer #(.DW(BYTE_W)) u_framer (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .op_fire(op_fire), .arg_fire(arg_fire), .op_q(op_q)
  );

  gcd_regs #(.DW(BYTE_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .arg_fire(arg_fire), .op_q(op_q), .arg(byte_in),
    .clk_sel(clk_sel), .chan_en(chan_en), .seq_err(seq_err),
    .local_rst(local_rst), .dev_rst(dev_rst)
  );

  gcd_rdmux #(.DW(BYTE_W), .NCH(NCH), .VERSION(VERSION)) u_rdmux (
    .clk(clk), .rst(rst), .op_fire(op_fire), .op_in(byte_in),
    .clk_sel(clk_sel), .chan_en(chan_en), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_RD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(byte_valid)); // R3
  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(local_rst && dev_rst)); // R7
endmodule

// File: tb/test_glob_cmd_dec.sv
module test_glob_cmd_dec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       rd_valid, local_rst, dev_rst, seq_err;
  logic [7:0] rd_data, chan_en;
  logic [3:0] clk_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [3:0] m_clk;
  logic [7:0] m_en;
  logic       m_err;

  always #5 clk = ~clk;

  glob_cmd_dec i_glob_cmd_dec (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .clk_sel(clk_sel), .chan_en(chan_en),
    .local_rst(local_rst), .dev_rst(dev_rst), .seq_err(seq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [3:0] c);
    return c inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'hC, 4'hD, 4'hE};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] op);
    case (op)
      8'h20: return 8'h01;
      8'h24: return {4'h0, m_clk};
      8'h25: return m_en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one opcode/operand pair; checks every output against the model
  task automatic xfer(input logic [7:0] op, input logic [7:0] arg, input int gap);
    logic exp_lr, exp_dr;
    @(negedge clk);
    byte_valid = 1'b1; byte_in = op;
    @(negedge clk);
    byte_valid = 1'b0; byte_in = 8'h5A;
    if (!op[7]) begin
      chk("R3/R11 rd_valid", rd_valid, 1);
      chk("R3/R4/R6/R11 rd_data", rd_data, exp_read(op));
    end else chk("R11 no read on write", rd_valid, 0);
    idle(gap);
    byte_valid = 1'b1; byte_in = arg;
    exp_lr = 0; exp_dr = 0;
    if (op inside {8'hA0, 8'hA2, 8'hA3}) begin
      if (arg != 8'hFF) m_err = 1;
      else if (op == 8'hA2) exp_lr = 1;
      else if (op == 8'hA3) begin exp_dr = 1; m_clk = 4'h2; m_en = 0; m_err = 0; end
    end else if (op == 8'hA4) begin
      if (legal(arg[3:0])) m_clk = arg[3:0];
    end else if (op == 8'hA5) m_en = arg;
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R7 local_rst", local_rst, exp_lr);
    chk("R8 dev_rst", dev_rst, exp_dr);
    chk("R4/R5 clk_sel", clk_sel, m_clk);
    chk("R6 chan_en", chan_en, m_en);
    chk("R9 seq_err", seq_err, m_err);
    chk("R2 rd_valid idle", rd_valid, 0);
    @(negedge clk);
    chk("R7/R8 pulse width", local_rst | dev_rst, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_clk = 4'h2; m_en = 0; m_err = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 clk_sel", clk_sel, 4'h2);
    chk("R1 chan_en", chan_en, 0);
    chk("R1 seq_err", seq_err, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 pulses", local_rst | dev_rst, 0);
    // directed corners
    xfer(8'h20, 8'h00, 0);        // R3
    xfer(8'hA4, 8'hF5, 1);        // R4 upper bits ignored
    xfer(8'h24, 8'h00, 2);        // R4 read back
    xfer(8'hA4, 8'h03, 0);        // R5 illegal
    xfer(8'hA4, 8'h0F, 0);        // R5 illegal
    xfer(8'hA5, 8'h81, 0);        // R6
    xfer(8'h25, 8'h00, 1);        // R6
    xfer(8'hA0, 8'hFF, 0);        // R10
    xfer(8'hA2, 8'hFF, 0);        // R7
    xfer(8'hA2, 8'h7F, 0);        // R9
    xfer(8'hA0, 8'h00, 2);        // R9 sticky
    xfer(8'h3C, 8'hA3, 0);        // R11 unknown read
    xfer(8'hBE, 8'hFF, 0);        // R11 unknown write
    xfer(8'hA3, 8'hFF, 1);        // R8
    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [7:0] ops [10] = '{8'h20, 8'h24, 8'h25, 8'hA0, 8'hA2, 8'hA3,
                               8'hA4, 8'hA5, 8'h11, 8'hC7};
      logic [7:0] op, arg;
      op  = ops[$urandom_range(0, 9)];
      arg = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
      if (op == 8'hA3 && $urandom_range(0, 3) != 0) arg = 8'h00;
      xfer(op, arg, $urandom_range(0, 2));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule